// File: doc/BRIEF.md
# Power-Down Level Event Latch

This block holds a record of up to eight level-sensitive power-down or wake conditions. It keeps that record even while the register-bus clock is stopped. Each channel compares its input pin with a per-channel polarity bit. While the chosen level is present, an asynchronously set storage cell is forced to one. No clock edge is needed for this. The cell stays set after the input goes away, until software clears it with a write-one-to-clear access and the input is inactive.

The stored bits pass through a synchronizer of configurable depth into the bus clock domain. Software reads them there as raw status, and as masked status after the per-channel enable is applied. The single interrupt output is high whenever any masked bit is set. Only level detection is built in. Software gets edge behaviour by inverting a channel's polarity after each event. Flipping a polarity onto the level the pin already has sets that channel at once. There is no register for reading back the live pin level.

The register port is a simple single-cycle bus. A write is taken on the clock edge where select and write are both high. Read data is combinational from the address. Register offsets: enable 0x00, raw status 0x04, masked status 0x08, clear 0x0C, polarity 0x10, mode 0x14. Channel n uses data bit n in every register.

Top module: `pdwn_irq_latch`

## Requirements
- R1: After reset, every register (0x00, 0x04, 0x08, 0x0C, 0x10, 0x14) reads zero and irq_o is low. Asserting rst_n also drops any latched status whose input is inactive.
- R2: With polarity bit n = 0, a high level on wake_i[n] sets raw status bit n at offset 0x04.
- R3: With polarity bit n = 1, a low level on wake_i[n] sets raw status bit n.
- R4: A set status bit stays set after its input returns to the inactive level.
- R5: Masked status at 0x08 equals raw status AND enable (0x00), and irq_o is high exactly when any masked bit is set. Clearing the enable drops irq_o without touching raw status.
- R6: Writing 1 to bit n of the clear register (0x0C) clears channel n when its input is inactive. Bits written as 0 leave their channels unchanged.
- R7: A clear request for a channel whose input is still active leaves that channel's status set.
- R8: An active level that comes and goes while the bus clock is stopped is still recorded, and it reads back once the clock runs again.
- R9: The mode register (0x14) and the clear register read as zero. Writes to the mode register have no effect: capture stays level-based.
- R10: Changing a polarity bit so that the pin's present level becomes active sets that channel's status.
- R11: A raw status change becomes visible on reads exactly SYNC_STAGES bus clock edges after the storage cell changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-bus clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | NCH | Level inputs, one per channel |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data; bit n is channel n |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_o | output | 1 | OR of the masked status bits |

## Verification
The bench builds the block with eight channels and a three-stage synchronizer, one stage deeper than the default. This moves the read-visibility latency off its default value, so a latency assumed as fixed rather than taken from the parameter shows up in the cycle-exact R11 check. Eight channels allow polarity and enable patterns that mix active-high and active-low bits, so cross-channel mix-ups are exposed. The clock generator can be halted, which lets an input pulse arrive and leave with no clock edge at all.

// File: rtl/pdwn_pkg.sv
package pdwn_pkg;
  // register byte offsets
  localparam int unsigned OFF_ENABLE = 32'h00;
  localparam int unsigned OFF_RAW    = 32'h04;
  localparam int unsigned OFF_MASKED = 32'h08;
  localparam int unsigned OFF_CLEAR  = 32'h0C;
  localparam int unsigned OFF_POLAR  = 32'h10;
  localparam int unsigned OFF_MODE   = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLEAR,
    SEL_POLAR,
    SEL_MODE
  } reg_sel_e;
endpackage

// File: rtl/pdwn_latch_cell.sv
// Clockless capture cell: set by an active level, cleared by a pulse.
// Set has priority, so a clear that meets an active level is ignored.
module pdwn_latch_cell (
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge set_i or posedge clr_i) begin
    if (set_i) q_o <= 1'b1;
    else       q_o <= 1'b0;
  end
endmodule

// File: rtl/pdwn_sync.sv
// Multi-stage synchronizer into the bus clock domain.
module pdwn_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pdwn_regs.sv
// Register file: enable and polarity storage, clear pulse, read mux.
module pdwn_regs
  import pdwn_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NCH-1:0]    raw_s_i,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    pol_o,
  output logic [NCH-1:0]    clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e       sel_w;
  logic           wr_stb;
  logic           en_we;
  logic           pol_we;
  logic [NCH-1:0] en_q, en_d;
  logic [NCH-1:0] pol_q, pol_d;
  logic [NCH-1:0] clr_q, clr_d;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NCH];

  // address decode
  always_comb begin
    sel_w = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFF_ENABLE)) sel_w = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFF_RAW))    sel_w = SEL_RAW;
    else if (bus_addr == ADDR_W'(OFF_MASKED)) sel_w = SEL_MASKED;
    else if (bus_addr == ADDR_W'(OFF_CLEAR))  sel_w = SEL_CLEAR;
    else if (bus_addr == ADDR_W'(OFF_POLAR))  sel_w = SEL_POLAR;
    else if (bus_addr == ADDR_W'(OFF_MODE))   sel_w = SEL_MODE;
  end

  assign wr_stb = bus_sel & bus_wr;
  assign en_we  = wr_stb & (sel_w == SEL_ENABLE);
  assign pol_we = wr_stb & (sel_w == SEL_POLAR);

  // next state
  always_comb begin
    en_d  = bus_wdata[NCH-1:0];
    pol_d = bus_wdata[NCH-1:0];
    clr_d = '0;
    if (wr_stb && (sel_w == SEL_CLEAR)) clr_d = bus_wdata[NCH-1:0];
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= pol_d;
  end

  // clear is a one-cycle pulse per channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= '0;
    else        clr_q <= clr_d;
  end

  // read mux; clear and mode read back as zero
  always_comb begin
    rdata_o = '0;
    unique case (sel_w)
      SEL_ENABLE: rdata_o[NCH-1:0] = en_q;
      SEL_RAW:    rdata_o[NCH-1:0] = raw_s_i;
      SEL_MASKED: rdata_o[NCH-1:0] = raw_s_i & en_q;
      SEL_POLAR:  rdata_o[NCH-1:0] = pol_q;
      default:    rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/pdwn_irq_latch.sv
// Top: clockless level capture, synchronizer, registers, interrupt.
module pdwn_irq_latch #(
  parameter int NCH         = 8,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wake_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic [RST_STAGES-1:0] rst_pipe_d;
  logic                  rst_int_n;
  logic [NCH-1:0]        en_vec;
  logic [NCH-1:0]        pol_vec;
  logic [NCH-1:0]        clr_pulse;
  logic [NCH-1:0]        active;
  logic [NCH-1:0]        cell_clr;
  logic [NCH-1:0]        cell_q;
  logic [NCH-1:0]        raw_sync;

  // reset: asserted asynchronously, released on the clock
  always_comb begin
    rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  // polarity 0 = active high, 1 = active low
  assign active   = wake_i ^ pol_vec;
  assign cell_clr = clr_pulse | {NCH{~rst_n}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cell
    pdwn_latch_cell u_cell (
      .set_i (active[ch]),
      .clr_i (cell_clr[ch]),
      .q_o   (cell_q[ch])
    );
  end

  pdwn_sync #(
    .W      (NCH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (cell_q),
    .q_o   (raw_sync)
  );

  pdwn_regs #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_s_i   (raw_sync),
    .en_o      (en_vec),
    .pol_o     (pol_vec),
    .clr_o     (clr_pulse),
    .rdata_o   (bus_rdata)
  );

  assign irq_o = |(raw_sync & en_vec);
endmodule

// File: rtl/pdwn_irq_latch_chk.sv
module pdwn_irq_latch_chk
  import pdwn_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [NCH-1:0]    en_vec,
  input logic [NCH-1:0]    raw_sync
);
  logic [NCH-1:0] clr_seen_q;
  logic [NCH-1:0] raw_prev_q;

  // remember a clear request per channel until its status rises again
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_seen_q <= '0;
      raw_prev_q <= '0;
    end else begin
      raw_prev_q <= raw_sync;
      for (int i = 0; i < NCH; i++) begin
        if (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CLEAR) && bus_wdata[i])
          clr_seen_q[i] <= 1'b1;
        else if (raw_sync[i] && !raw_prev_q[i])
          clr_seen_q[i] <= 1'b0;
      end
    end
  end

  AST_MODE_CLEAR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_MODE) || bus_addr == ADDR_W'(OFF_CLEAR)))
      |-> bus_rdata == '0); // R9

  AST_MASKED_WITHIN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_MASKED))
      |-> (bus_rdata[NCH-1:0] & ~en_vec) == '0); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_vec != '0); // R5

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(raw_sync[ch]) |-> clr_seen_q[ch]); // R4
  end
endmodule

bind pdwn_irq_latch pdwn_irq_latch_chk #(
  .NCH    (NCH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .en_vec    (en_vec),
  .raw_sync  (raw_sync)
);

// File: tb/pdwn_irq_latch_tb_top.sv
module pdwn_irq_latch_tb_top;
  localparam int NCH    = 8;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int SYNC   = 3;

  localparam logic [ADDR_W-1:0] A_EN  = 5'h00;
  localparam logic [ADDR_W-1:0] A_RAW = 5'h04;
  localparam logic [ADDR_W-1:0] A_MSK = 5'h08;
  localparam logic [ADDR_W-1:0] A_CLR = 5'h0C;
  localparam logic [ADDR_W-1:0] A_POL = 5'h10;
  localparam logic [ADDR_W-1:0] A_MOD = 5'h14;

  // {polarity, enable, wake, exp_raw, exp_masked, exp_irq}
  localparam int NVEC = 6;
  localparam logic [40:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 8'h01, 8'h01, 8'h01, 1'b1},
    {8'h00, 8'h0F, 8'hF0, 8'hF0, 8'h00, 1'b0},
    {8'hFF, 8'hFF, 8'hFE, 8'h01, 8'h01, 1'b1},
    {8'hF0, 8'h3C, 8'h00, 8'hF0, 8'h30, 1'b1},
    {8'h0F, 8'hA5, 8'h5A, 8'h55, 8'h05, 1'b1},
    {8'hAA, 8'h00, 8'hAA, 8'h00, 8'h00, 1'b0}
  };

  logic              clk = 1'b0;
  logic              clk_run = 1'b1;
  logic              rst_n = 1'b1;
  logic [NCH-1:0]    wake = '0;
  logic              sel = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  pdwn_irq_latch #(
    .NCH         (NCH),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_i    (wake),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = {24'h0, d};
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every register and the interrupt
    bus_read(A_EN,  d); check("R1 enable",   d, 0);
    bus_read(A_RAW, d); check("R1 raw",      d, 0);
    bus_read(A_MSK, d); check("R1 masked",   d, 0);
    bus_read(A_CLR, d); check("R1 clear",    d, 0);
    bus_read(A_POL, d); check("R1 polarity", d, 0);
    bus_read(A_MOD, d); check("R1 mode",     d, 0);
    check("R1 irq", {31'h0, irq}, 0);

    // vector table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] vp, ve, vw, xr, xm;
      logic       xi;
      {vp, ve, vw, xr, xm, xi} = VEC[v];
      @(negedge clk); wake = vp;
      bus_write(A_POL, vp);
      bus_write(A_EN, ve);
      bus_write(A_CLR, 8'hFF);
      settle();
      @(negedge clk); wake = vw;
      settle();
      bus_read(A_RAW, d); check($sformatf("R2/R3 raw vec%0d", v), d, {24'h0, xr});
      bus_read(A_MSK, d); check($sformatf("R5 masked vec%0d", v), d, {24'h0, xm});
      check($sformatf("R5 irq vec%0d", v), {31'h0, irq}, {31'h0, xi});
      @(negedge clk); wake = vp;
      settle();
      bus_read(A_RAW, d); check($sformatf("R4 held vec%0d", v), d, {24'h0, xr});
    end

    // return to active-high, everything cleared
    @(negedge clk); wake = '0;
    bus_write(A_POL, 8'h00);
    bus_write(A_EN, 8'h00);
    bus_write(A_CLR, 8'hFF);
    settle();

    // R11: raw visible exactly SYNC edges after capture
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = A_RAW;
    wake = 8'h01;
    repeat (SYNC - 1) @(negedge clk);
    #2 check("R11 before latency", rdata, 0);
    @(negedge clk);
    #2 check("R11 at latency", rdata, 32'h01);
    sel = 1'b0;
    @(negedge clk); wake = '0;
    bus_write(A_CLR, 8'h01);
    settle();

    // R6: selective clear, zero bits ignored
    @(negedge clk); wake = 8'h81;
    settle();
    @(negedge clk); wake = 8'h00;
    bus_write(A_CLR, 8'h01);
    settle();
    bus_read(A_RAW, d); check("R6 clear bit0 only", d, 32'h80);
    bus_write(A_CLR, 8'h00);
    settle();
    bus_read(A_RAW, d); check("R6 zero write no effect", d, 32'h80);
    bus_write(A_CLR, 8'h80);
    settle();
    bus_read(A_RAW, d); check("R6 clear bit7", d, 0);

    // R7: clear while input active is ignored
    @(negedge clk); wake = 8'h40;
    settle();
    bus_write(A_CLR, 8'h40);
    settle();
    bus_read(A_RAW, d); check("R7 clear while active", d, 32'h40);
    @(negedge clk); wake = 8'h00;
    settle();
    bus_read(A_RAW, d); check("R7 still held after release", d, 32'h40);
    bus_write(A_CLR, 8'h40);
    settle();
    bus_read(A_RAW, d); check("R7 clear once inactive", d, 0);

    // R8: capture with the bus clock stopped
    @(negedge clk);
    clk_run = 1'b0;
    #5 wake = 8'h04;
    #30 wake = 8'h00;
    #50 clk_run = 1'b1;
    settle();
    bus_read(A_RAW, d); check("R8 captured without clock", d, 32'h04);
    bus_write(A_CLR, 8'h04);
    settle();

    // R10: polarity flip onto present level sets status
    bus_read(A_RAW, d); check("R10 start clear", d, 0);
    bus_write(A_POL, 8'h02);
    settle();
    bus_read(A_RAW, d); check("R10 flip sets status", d, 32'h02);
    bus_write(A_POL, 8'h00);
    bus_write(A_CLR, 8'h02);
    settle();

    // R5: removing enable drops irq, raw stays
    bus_write(A_EN, 8'h01);
    @(negedge clk); wake = 8'h01;
    settle();
    @(negedge clk); wake = 8'h00;
    check("R5 irq with enable", {31'h0, irq}, 1);
    bus_write(A_EN, 8'h00);
    check("R5 irq after disable", {31'h0, irq}, 0);
    bus_read(A_RAW, d); check("R5 raw kept after disable", d, 32'h01);
    bus_write(A_CLR, 8'h01);
    settle();

    // R9: mode and clear read zero, mode write changes nothing
    bus_write(A_MOD, 8'hFF);
    bus_read(A_MOD, d); check("R9 mode reads zero", d, 0);
    bus_read(A_CLR, d); check("R9 clear reads zero", d, 0);
    @(negedge clk); wake = 8'h08;
    settle();
    @(negedge clk); wake = 8'h00;
    settle();
    bus_read(A_RAW, d); check("R9 level capture after mode write", d, 32'h08);

    // R1: reset drops latched status and registers
    bus_write(A_EN, 8'hFF);
    do_reset();
    bus_read(A_RAW, d); check("R1 raw after reset", d, 0);
    bus_read(A_EN,  d); check("R1 enable after reset", d, 0);
    check("R1 irq after reset", {31'h0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule